// File: doc/BRIEF.md
# Timestamped Multi-Packet Transmit Scheduler

This block holds a small table of transmit packets whose samples already sit in one shared sample RAM. Each table slot records where its packet starts in the RAM, the time at which it is due, and how many words remain. A free-running time value supplied from outside is compared against every slot. Once a packet is due, it takes part in every sweep that follows. A sweep visits the slots in index order and reads one RAM word for each packet that was due when the sweep began. The words are collected into one lane per slot, and a single transfer hands the whole set to the transmit chain. This lets several packets with the same start time run side by side, interleaved word by word, without a FIFO per channel.

Packets come in over a valid/ready enqueue stream. A beat is accepted whenever a slot is free, and that includes a slot that frees up in the same cycle. The slot chosen is the lowest-numbered free one, and it fixes the output lane. The output is also valid/ready: the transmit chain can hold a set back by keeping `ship_ready` low. The set and its mask then stay frozen, and the next sweep waits at its first slot until the set is taken. With `ship_ready` held high, sweeps run back to back with a fixed period.

Top module: `ts_pkt_sched`

## Requirements
- R1: After reset, `full` is 0, `enq_ready` is 1, `ship_valid` is 0 and `ram_rd_en` is 0.
- R2: A slot is due when `now_ts` is greater than or equal to its start time, with the lowest `TS_DROP` bits of both ignored (2 by default). A packet whose start time has already passed begins at the next sweep.
- R3: An accepted packet goes into the lowest-numbered free slot, and slot i always drives lane i. Lane i is bits [16*i+15:16*i] of `ship_data`, and bit i of `ship_mask` marks it. Every packet that is due when a sweep begins gets exactly one word in that sweep.
- R4: Each packet reads from its start address upward by one word per sweep, and the address wraps modulo 2^`ADDR_W` (64 by default).
- R5: A packet of length L produces exactly L output words and then frees its slot. An enqueue beat with length 0 is accepted but stores nothing and produces no output.
- R6: `ship_valid` is raised only when at least one lane carries data. Every lane whose `ship_mask` bit is 0 reads as zero.
- R7: With `ship_ready` held high, sweeps start every N+1 cycles, where N = `NUM_CH`+1 = 4 slots. A packet that is still running therefore gives output transfers exactly 5 cycles apart.
- R8: `full` is 1 exactly when all slots are occupied. `enq_ready` is 1 when some slot is free or is retiring in that cycle. A retire and an enqueue in the same cycle both take effect, so `full` stays 1 throughout.
- R9: While `ship_valid` is 1 and `ship_ready` is 0, `ship_valid`, `ship_mask` and `ship_data` hold steady. No further word is read until the set is taken.
- R10: RAM read data is expected one cycle after `ram_rd_en`, at the address given with it. That word appears in the lane of the slot that issued the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_ts | input | 32 | Free-running time value |
| enq_valid | input | 1 | Enqueue beat present |
| enq_ready | output | 1 | Enqueue beat can be accepted |
| enq_ptr | input | 6 | RAM address of the packet's first word |
| enq_time | input | 32 | Time at which the packet becomes due |
| enq_len | input | 8 | Packet length in words |
| full | output | 1 | All slots occupied |
| ram_rd_en | output | 1 | RAM read request |
| ram_rd_addr | output | 6 | RAM read address |
| ram_rd_data | input | 16 | RAM read data, one cycle after the request |
| ship_valid | output | 1 | Output sample set present |
| ship_ready | input | 1 | Transmit chain takes the set |
| ship_mask | output | 4 | Lanes carrying data in this set |
| ship_data | output | 64 | Four 16-bit lanes, lane i at bits [16*i+15:16*i] |

## Verification
The bench goes after the following corner cases, each in terms of what a faulty design would do:
- Three packets due at the same time, one of which wraps past the top of the RAM. A design that serviced only one due slot per sweep, or lost the wrap, would ship the wrong masks or wrong words.
- A start time that differs from `now_ts` only in the ignored low bits. Full-resolution comparison would delay that packet.
- A full table where one slot retires while a new packet waits. If retire and enqueue were serialised, `full` would dip for a cycle or the new packet would be lost.
- A zero-length packet, which a careless design would run forever.
- A stalled output that must stay frozen and must not race ahead with further reads.
- The spacing of output transfers, which shows whether the sweep period is fixed.

// File: rtl/ts_sched_pkg.sv
package ts_sched_pkg;

  // Sweep sequencing: visit each slot, then one closing cycle that
  // publishes the collected set and snapshots the due slots.
  typedef enum logic {
    PH_READ  = 1'b0,
    PH_CLOSE = 1'b1
  } sweep_ph_e;

  localparam int DEF_NUM_CH  = 3;
  localparam int DEF_ADDR_W  = 6;
  localparam int DEF_DATA_W  = 16;
  localparam int DEF_TS_W    = 32;
  localparam int DEF_TS_DROP = 2;
  localparam int DEF_LEN_W   = 8;

endpackage

// File: rtl/ts_sched_alloc.sv
// Picks the lowest-numbered free slot.
module ts_sched_alloc #(
  parameter int N = 4
) (
  input  logic [N-1:0] free_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);

  logic [N:0] taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pick
    assign grant_o[i]  = free_i[i] & ~taken[i];
    assign taken[i+1]  = taken[i] | free_i[i];
  end

  assign any_o = taken[N];

endmodule

// File: rtl/ts_sched_table.sv
// Slot storage: start address, start time key, remaining length.
module ts_sched_table #(
  parameter int N       = 4,
  parameter int ADDR_W  = 6,
  parameter int TS_W    = 32,
  parameter int TS_DROP = 2,
  parameter int LEN_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [TS_W-1:0]               now_ts,
  input  logic [N-1:0]                  wr_sel,
  input  logic [ADDR_W-1:0]             wr_ptr,
  input  logic [TS_W-1:0]               wr_time,
  input  logic [LEN_W-1:0]              wr_len,
  input  logic                          adv_en,
  input  logic [$clog2(N)-1:0]          adv_idx,
  output logic [N-1:0]                  valid_o,
  output logic [N-1:0]                  due_o,
  output logic [N-1:0]                  retire_o,
  output logic [ADDR_W-1:0]             adv_ptr
);

  localparam int IDX_W = $clog2(N);
  localparam int KEY_W = TS_W - TS_DROP;

  logic [N-1:0]             vld_q;
  logic [ADDR_W-1:0]        ptr_q   [N];
  logic [KEY_W-1:0]         key_q   [N];
  logic [LEN_W-1:0]         len_q   [N];
  logic [KEY_W-1:0]         now_key;
  logic [N-1:0]             hit;

  assign now_key = now_ts[TS_W-1:TS_DROP];

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign hit[i]      = adv_en && (adv_idx == IDX_W'(i));
    assign retire_o[i] = hit[i] && (len_q[i] == LEN_W'(1));
    assign due_o[i]    = vld_q[i] && (now_key >= key_q[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < N; i++) begin
        ptr_q[i] <= '0;
        key_q[i] <= '0;
        len_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (wr_sel[i]) begin
          // a fresh packet wins over the retire of the old one
          vld_q[i] <= 1'b1;
          ptr_q[i] <= wr_ptr;
          key_q[i] <= wr_time[TS_W-1:TS_DROP];
          len_q[i] <= wr_len;
        end else if (hit[i]) begin
          ptr_q[i] <= ptr_q[i] + ADDR_W'(1);
          len_q[i] <= len_q[i] - LEN_W'(1);
          if (len_q[i] == LEN_W'(1)) vld_q[i] <= 1'b0;
        end
      end
    end
  end

  assign valid_o = vld_q;
  assign adv_ptr = ptr_q[adv_idx];

endmodule

// File: rtl/ts_sched_sweep.sv
// Round sequencer: one read per due slot, then publish the set.
module ts_sched_sweep
  import ts_sched_pkg::*;
#(
  parameter int N      = 4,
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              slot_due,
  output logic                      rd_en,
  output logic [$clog2(N)-1:0]      rd_idx,
  input  logic [DATA_W-1:0]         ram_rd_data,
  output logic                      ship_valid,
  input  logic                      ship_ready,
  output logic [N-1:0]              ship_mask,
  output logic [N*DATA_W-1:0]       ship_data
);

  localparam int IDX_W = $clog2(N);

  sweep_ph_e                    ph_q;
  logic [IDX_W-1:0]             idx_q;
  logic [N-1:0]                 mask_q;
  logic [N-1:0][DATA_W-1:0]     stage_q;
  logic [N-1:0][DATA_W-1:0]     merged;
  logic                         cap_v_q;
  logic [IDX_W-1:0]             cap_idx_q;
  logic                         out_v_q;
  logic [N-1:0]                 out_m_q;
  logic [N-1:0][DATA_W-1:0]     out_d_q;
  logic                         stall;
  logic                         go;
  logic                         last;

  // hold the first slot while the previous set is still unclaimed
  assign stall = (idx_q == '0) && out_v_q && !ship_ready;
  assign go    = (ph_q == PH_READ) && !stall;
  assign last  = (idx_q == IDX_W'(N-1));
  assign rd_en  = go && mask_q[idx_q];
  assign rd_idx = idx_q;

  always_comb begin
    merged = stage_q;
    if (cap_v_q) merged[cap_idx_q] = ram_rd_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= PH_READ;
      idx_q     <= '0;
      mask_q    <= '0;
      stage_q   <= '0;
      cap_v_q   <= 1'b0;
      cap_idx_q <= '0;
      out_v_q   <= 1'b0;
      out_m_q   <= '0;
      out_d_q   <= '0;
    end else begin
      cap_v_q   <= rd_en;
      cap_idx_q <= idx_q;
      if (out_v_q && ship_ready) out_v_q <= 1'b0;
      case (ph_q)
        PH_READ: begin
          if (cap_v_q) stage_q[cap_idx_q] <= ram_rd_data;
          if (go) begin
            if (last) ph_q <= PH_CLOSE;
            else      idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: begin
          ph_q    <= PH_READ;
          idx_q   <= '0;
          stage_q <= '0;
          mask_q  <= slot_due;
          if (|mask_q) begin
            out_v_q <= 1'b1;
            out_m_q <= mask_q;
            out_d_q <= merged;
          end
        end
      endcase
    end
  end

  assign ship_valid = out_v_q;
  assign ship_mask  = out_m_q;
  assign ship_data  = out_d_q;

endmodule

// File: rtl/ts_pkt_sched.sv
module ts_pkt_sched
  import ts_sched_pkg::*;
#(
  parameter int NUM_CH  = DEF_NUM_CH,
  parameter int ADDR_W  = DEF_ADDR_W,
  parameter int DATA_W  = DEF_DATA_W,
  parameter int TS_W    = DEF_TS_W,
  parameter int TS_DROP = DEF_TS_DROP,
  parameter int LEN_W   = DEF_LEN_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [TS_W-1:0]               now_ts,
  input  logic                          enq_valid,
  output logic                          enq_ready,
  input  logic [ADDR_W-1:0]             enq_ptr,
  input  logic [TS_W-1:0]               enq_time,
  input  logic [LEN_W-1:0]              enq_len,
  output logic                          full,
  output logic                          ram_rd_en,
  output logic [ADDR_W-1:0]             ram_rd_addr,
  input  logic [DATA_W-1:0]             ram_rd_data,
  output logic                          ship_valid,
  input  logic                          ship_ready,
  output logic [NUM_CH:0]               ship_mask,
  output logic [(NUM_CH+1)*DATA_W-1:0]  ship_data
);

  localparam int N_SLOT = NUM_CH + 1;
  localparam int IDX_W  = $clog2(N_SLOT);

  logic [N_SLOT-1:0] valid_v;
  logic [N_SLOT-1:0] due_v;
  logic [N_SLOT-1:0] retire_v;
  logic [N_SLOT-1:0] free_v;
  logic [N_SLOT-1:0] grant_v;
  logic [N_SLOT-1:0] wr_sel;
  logic              any_free;
  logic              accept;
  logic              rd_en;
  logic [IDX_W-1:0]  rd_idx;

  assign free_v    = ~valid_v | retire_v;
  assign enq_ready = any_free;
  assign accept    = enq_valid && any_free && (enq_len != '0);
  assign wr_sel    = accept ? grant_v : '0;
  assign full      = &valid_v;

  ts_sched_alloc #(.N(N_SLOT)) u_alloc (
    .free_i  (free_v),
    .grant_o (grant_v),
    .any_o   (any_free)
  );

  ts_sched_table #(
    .N       (N_SLOT),
    .ADDR_W  (ADDR_W),
    .TS_W    (TS_W),
    .TS_DROP (TS_DROP),
    .LEN_W   (LEN_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .now_ts   (now_ts),
    .wr_sel   (wr_sel),
    .wr_ptr   (enq_ptr),
    .wr_time  (enq_time),
    .wr_len   (enq_len),
    .adv_en   (rd_en),
    .adv_idx  (rd_idx),
    .valid_o  (valid_v),
    .due_o    (due_v),
    .retire_o (retire_v),
    .adv_ptr  (ram_rd_addr)
  );

  ts_sched_sweep #(.N(N_SLOT), .DATA_W(DATA_W)) u_sweep (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_due    (due_v),
    .rd_en       (rd_en),
    .rd_idx      (rd_idx),
    .ram_rd_data (ram_rd_data),
    .ship_valid  (ship_valid),
    .ship_ready  (ship_ready),
    .ship_mask   (ship_mask),
    .ship_data   (ship_data)
  );

  assign ram_rd_en = rd_en;

endmodule

// File: rtl/ts_pkt_sched_chk.sv
module ts_pkt_sched_chk #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          enq_ready,
  input logic                          full,
  input logic                          ship_valid,
  input logic                          ship_ready,
  input logic [NUM_CH:0]               ship_mask,
  input logic [(NUM_CH+1)*DATA_W-1:0]  ship_data
);

  localparam int N_SLOT = NUM_CH + 1;
  localparam int GAP_W  = $clog2(N_SLOT + 2) + 1;

  logic [(NUM_CH+1)*DATA_W-1:0] idle_bits;
  logic                         v_d;
  logic                         v_rise;
  logic [GAP_W-1:0]             gap;

  for (genvar i = 0; i < N_SLOT; i++) begin : g_idle
    assign idle_bits[i*DATA_W +: DATA_W] = ship_mask[i] ? '0 : ship_data[i*DATA_W +: DATA_W];
  end

  assign v_rise = ship_valid && !v_d;

  // cycles since the previous rising output valid, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_d <= 1'b0;
      gap <= '1;
    end else begin
      v_d <= ship_valid;
      if (v_rise)      gap <= GAP_W'(1);
      else if (gap != '1) gap <= gap + GAP_W'(1);
    end
  end

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ship_valid && !ship_ready |=> ship_valid && $stable(ship_data) && $stable(ship_mask)); // R9

  AST_IDLE_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ship_valid |-> idle_bits == '0); // R6

  AST_SET_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ship_valid |-> ship_mask != '0); // R6

  AST_READY_IF_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> enq_ready); // R8

  AST_SWEEP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    v_rise |-> gap >= GAP_W'(N_SLOT + 1)); // R7

endmodule

bind ts_pkt_sched ts_pkt_sched_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enq_ready  (enq_ready),
  .full       (full),
  .ship_valid (ship_valid),
  .ship_ready (ship_ready),
  .ship_mask  (ship_mask),
  .ship_data  (ship_data)
);

// File: tb/test_ts_pkt_sched.sv
module test_ts_pkt_sched;

  localparam int NUM_CH = 3;
  localparam int N      = NUM_CH + 1;
  localparam int PERIOD = N + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] now_ts = '0;
  logic        enq_valid = 1'b0;
  logic        enq_ready;
  logic [5:0]  enq_ptr = '0;
  logic [31:0] enq_time = '0;
  logic [7:0]  enq_len = '0;
  logic        full;
  logic        ram_rd_en;
  logic [5:0]  ram_rd_addr;
  logic [15:0] ram_rd_data = '0;
  logic        ship_valid;
  logic        ship_ready = 1'b1;
  logic [3:0]  ship_mask;
  logic [63:0] ship_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nrec = 0;
  logic [3:0]  rec_mask [64];
  logic [63:0] rec_data [64];
  int          rec_cyc  [64];
  logic        watch_full = 1'b0;
  int          full_drops = 0;
  bit          finished = 1'b0;

  ts_pkt_sched i_ts_pkt_sched (
    .clk (clk), .rst_n (rst_n), .now_ts (now_ts),
    .enq_valid (enq_valid), .enq_ready (enq_ready), .enq_ptr (enq_ptr),
    .enq_time (enq_time), .enq_len (enq_len), .full (full),
    .ram_rd_en (ram_rd_en), .ram_rd_addr (ram_rd_addr), .ram_rd_data (ram_rd_data),
    .ship_valid (ship_valid), .ship_ready (ship_ready),
    .ship_mask (ship_mask), .ship_data (ship_data)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] pat(input logic [5:0] a);
    return 16'h1000 + 16'(a) * 16'd7;
  endfunction

  function automatic logic [63:0] lanes(input logic [15:0] l3, l2, l1, l0);
    return {l3, l2, l1, l0};
  endfunction

  // RAM model: one-cycle read latency (R10)
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ram_rd_en) ram_rd_data <= pat(ram_rd_addr);
  end

  always @(negedge clk) begin
    if (rst_n && ship_valid && ship_ready && nrec < 64) begin
      rec_mask[nrec] = ship_mask;
      rec_data[nrec] = ship_data;
      rec_cyc[nrec]  = cyc;
      nrec = nrec + 1;
    end
    if (watch_full && !full) full_drops = full_drops + 1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic wait_recs(input int n, input string req);
    int t = 0;
    while (nrec < n && t < 400) begin
      @(negedge clk);
      t++;
    end
    if (nrec < n) check(1'b0, req, 64'(nrec), 64'(n));
  endtask

  task automatic chk_rec(input int k, input logic [3:0] m, input logic [63:0] d, input string req);
    check(rec_mask[k] == m, {req, " mask"}, 64'(rec_mask[k]), 64'(m));
    check(rec_data[k] == d, {req, " data"}, rec_data[k], d);
  endtask

  task automatic enqueue(input logic [5:0] p, input logic [31:0] t, input logic [7:0] l);
    @(negedge clk);
    enq_valid = 1'b1; enq_ptr = p; enq_time = t; enq_len = l;
    while (!enq_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(full == 1'b0 && enq_ready == 1'b1 && ship_valid == 1'b0 && ram_rd_en == 1'b0,
          "R1 reset outputs", {60'd0, full, enq_ready, ship_valid, ram_rd_en}, 64'h4);
  endtask

  task automatic t_late_single();
    int b = nrec;
    now_ts = 32'd100;
    enqueue(6'd10, 32'd50, 8'd3);
    wait_recs(b + 3, "R2 late packet");
    chk_rec(b + 0, 4'b0001, lanes(0, 0, 0, pat(10)), "R10 first word");
    chk_rec(b + 1, 4'b0001, lanes(0, 0, 0, pat(11)), "R4 step");
    chk_rec(b + 2, 4'b0001, lanes(0, 0, 0, pat(12)), "R4 step");
    idle(30);
    check(nrec == b + 3, "R5 retire after length", 64'(nrec - b), 64'd3);
  endtask

  task automatic t_resolution();
    int b = nrec;
    now_ts = 32'h17F;
    enqueue(6'd33, 32'h183, 8'd1);
    idle(30);
    check(nrec == b, "R2 not due early", 64'(nrec - b), 64'd0);
    now_ts = 32'h180;
    wait_recs(b + 1, "R2 reduced resolution");
    chk_rec(b, 4'b0001, lanes(0, 0, 0, pat(33)), "R2 reduced resolution");
    idle(20);
  endtask

  task automatic t_interleave();
    int b = nrec;
    now_ts = 32'd900;
    enqueue(6'd20, 32'd1000, 8'd2);
    enqueue(6'd40, 32'd1000, 8'd4);
    enqueue(6'd62, 32'd1000, 8'd3);
    idle(20);
    check(nrec == b, "R2 wait for start", 64'(nrec - b), 64'd0);
    now_ts = 32'd1000;
    wait_recs(b + 4, "R3 interleave");
    chk_rec(b + 0, 4'b0111, lanes(0, pat(62), pat(40), pat(20)), "R3 same start");
    chk_rec(b + 1, 4'b0111, lanes(0, pat(63), pat(41), pat(21)), "R3 second round");
    chk_rec(b + 2, 4'b0110, lanes(0, pat(0), pat(42), 0), "R4 wrap");
    chk_rec(b + 3, 4'b0010, lanes(0, 0, pat(43), 0), "R6 idle lanes zero");
    for (int k = 1; k < 4; k++)
      check(rec_cyc[b + k] - rec_cyc[b + k - 1] == PERIOD, "R7 period",
            64'(rec_cyc[b + k] - rec_cyc[b + k - 1]), 64'(PERIOD));
    idle(20);
  endtask

  task automatic t_full_swap();
    int b = nrec;
    now_ts = 32'd2000;
    enqueue(6'd30, 32'd3000, 8'd1);
    enqueue(6'd50, 32'd8000, 8'd1);
    enqueue(6'd51, 32'd8000, 8'd1);
    enqueue(6'd52, 32'd8000, 8'd1);
    @(negedge clk);
    check(full == 1'b1 && enq_ready == 1'b0, "R8 full", {62'd0, full, enq_ready}, 64'h2);
    watch_full = 1'b1;
    fork
      enqueue(6'd5, 32'd3000, 8'd2);
      begin idle(3); now_ts = 32'd3000; end
    join
    wait_recs(b + 2, "R8 swap");
    watch_full = 1'b0;
    check(full_drops == 0, "R8 full held during swap", 64'(full_drops), 64'd0);
    wait_recs(b + 3, "R8 swap tail");
    chk_rec(b + 0, 4'b0001, lanes(0, 0, 0, pat(30)), "R8 old packet");
    chk_rec(b + 1, 4'b0001, lanes(0, 0, 0, pat(5)), "R8 new packet");
    chk_rec(b + 2, 4'b0001, lanes(0, 0, 0, pat(6)), "R8 new packet");
    now_ts = 32'd8000;
    wait_recs(b + 4, "R3 upper slots");
    chk_rec(b + 3, 4'b1110, lanes(pat(52), pat(51), pat(50), 0), "R3 upper slots");
    idle(20);
  endtask

  task automatic t_zero_len();
    int b = nrec;
    now_ts = 32'd10000;
    enqueue(6'd7, 32'd0, 8'd0);
    idle(30);
    check(nrec == b, "R5 zero length no output", 64'(nrec - b), 64'd0);
    check(full == 1'b0 && enq_ready == 1'b1, "R5 zero length no slot", {62'd0, full, enq_ready}, 64'h1);
  endtask

  task automatic t_backpressure();
    int b = nrec;
    int t = 0;
    logic [63:0] held;
    bit steady = 1'b1;
    ship_ready = 1'b0;
    now_ts = 32'd11000;
    enqueue(6'd8, 32'd11000, 8'd2);
    while (!ship_valid && t < 100) begin @(negedge clk); t++; end
    held = ship_data;
    check(ship_valid && held == lanes(0, 0, 0, pat(8)), "R9 stalled set", held, lanes(0, 0, 0, pat(8)));
    repeat (12) begin
      @(negedge clk);
      if (!ship_valid || ship_data != held || ship_mask != 4'b0001 || ram_rd_en) steady = 1'b0;
    end
    check(steady, "R9 hold while stalled", 64'(steady), 64'd1);
    ship_ready = 1'b1;
    wait_recs(b + 2, "R9 release");
    chk_rec(b + 0, 4'b0001, lanes(0, 0, 0, pat(8)), "R9 release");
    chk_rec(b + 1, 4'b0001, lanes(0, 0, 0, pat(9)), "R9 next word");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_late_single();
    t_resolution();
    t_interleave();
    t_full_swap();
    t_zero_len();
    t_backpressure();
    idle(10);
    finish_run();
  end

endmodule